// File: doc/BRIEF.md
# Serializer Link Control Sequencer

This block is the digital framing and link-control side of a 10-bit parallel-to-serial transmitter. A 10-bit word on `par_data` is captured once per reference-clock period, on the rising or the falling reference edge as chosen by `edge_sel`. Each reference period becomes one 12-bit frame slot on `ser_out`. The slot carries either that captured word between a start and a stop bit, or a fixed alignment pattern when a sync request is raised.

The whole block runs on `bit_clk`, a bit clock at twelve times the reference frequency and phase-aligned to it. The reference clock is oversampled through a short synchronizer, and its edges drive the word capture, the frame starts and a lock counter. `locked` rises only after 2049 reference rising edges have been counted since power-down was released. The serial output-enable `ser_oe` stays low (output high impedance) until lock, whenever `out_en` is low, and at once when `pwr_down` is raised.

Top module: `ser_link_seq`

## Requirements
- R1: A data frame is 12 bits sent LSB first on `ser_out`, one bit per `bit_clk` cycle: slot bit 0 is a start bit of 1, slot bits 1 to 10 carry word bits 0 to 9, and slot bit 11 is a stop bit of 0. The start bit appears on the third `bit_clk` rising edge after a `ref_clk` rising edge (SYNC_STAGES+1 edges).
- R2: With `edge_sel` high, the word present at a `ref_clk` rising edge is captured and sent in the frame started by the next `ref_clk` rising edge.
- R3: With `edge_sel` low, the word present at a `ref_clk` falling edge is captured and sent in the frame started by the following `ref_clk` rising edge.
- R4: `locked` goes high on the `bit_clk` edge that acts on the 2049th `ref_clk` rising edge counted since power-down release, and not earlier.
- R5: `ser_oe` is never high while `locked` is low.
- R6: `ser_oe` is registered: it is high in a cycle exactly when `locked` and `out_en` were both high at the preceding `bit_clk` edge, so `out_en` low forces high impedance whatever the lock state.
- R7: Raising `pwr_down` drives `locked` and `ser_oe` low at once, and clears the lock count, the held word (to 0) and the frame register. After release the block stays in reset for two `bit_clk` edges, and lock counting restarts from zero.
- R8: If `sync_req_a` or `sync_req_b` is high when a `ref_clk` rising edge is sampled, that slot carries six ones followed by six zeros in place of a data frame.
- R9: Once high, `locked` stays high until `pwr_down` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock, 12x the reference, phase-aligned |
| ref_clk | input | 1 | Reference clock; its edges strobe data and start frames |
| pwr_down | input | 1 | Power-down, asynchronous assert, high active |
| edge_sel | input | 1 | 1: capture on rising reference edge; 0: on falling |
| sync_req_a | input | 1 | Sync pattern request, first source |
| sync_req_b | input | 1 | Sync pattern request, second source |
| out_en | input | 1 | Enable for the serial output driver |
| par_data | input | 10 | Parallel word, bit 0 sent first |
| ser_out | output | 1 | Serial bit stream |
| ser_oe | output | 1 | Serial driver enable (low = high impedance) |
| locked | output | 1 | Lock declared |

## Verification
The checker asserts on every cycle that the enable never runs ahead of lock, that it follows the previous cycle's `out_en`, that lock is sticky and rises only on a reference edge event, that each load puts a start bit on the line, and that power-down silences the outputs. What cannot be seen at that level is the bench's work. That covers the exact 2049-edge lock count, which reference edge captures the word under each `edge_sel` setting, the bit order and payload of data and sync slots, and the restart of counting after a power-down that interrupts an unfinished count.

// File: rtl/ser_link_pkg.sv
package ser_link_pkg;
  localparam int unsigned DEF_WORD_W      = 10;
  localparam int unsigned DEF_LOCK_EDGES  = 2049;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    STROBE_FALL = 1'b0,
    STROBE_RISE = 1'b1
  } strobe_e;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic async_rst,
  output logic rst_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge async_rst) begin
    if (async_rst) pipe <= '1;
    else           pipe <= {pipe[STAGES-2:0], 1'b0};
  end

  assign rst_o = pipe[STAGES-1];
endmodule

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              ref_clk,
  input  logic [DATA_W-1:0] data_in,
  input  logic              sync_in,
  output logic              rise_o,
  output logic              fall_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sync_o
);
  localparam int unsigned CAP_W = DATA_W + 1;

  logic [STAGES:0]  ref_sh;
  logic [CAP_W-1:0] cap_sh [STAGES];

  always_ff @(posedge clk) begin
    ref_sh <= {ref_sh[STAGES-1:0], ref_clk};
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_cap
    if (i == 0) begin : g_first
      always_ff @(posedge clk) cap_sh[0] <= {sync_in, data_in};
    end else begin : g_next
      always_ff @(posedge clk) cap_sh[i] <= cap_sh[i-1];
    end
  end

  assign rise_o = ref_sh[STAGES-1] & ~ref_sh[STAGES];
  assign fall_o = ~ref_sh[STAGES-1] & ref_sh[STAGES];
  assign data_o = cap_sh[STAGES-1][DATA_W-1:0];
  assign sync_o = cap_sh[STAGES-1][DATA_W];
endmodule

// File: rtl/ser_lock_ctr.sv
module ser_lock_ctr #(
  parameter int unsigned LOCK_EDGES = 2049
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(LOCK_EDGES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      lock_o <= 1'b0;
    end else if (tick && !lock_o) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LOCK_EDGES - 1)) lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sync_sel,
  input  logic [DATA_W-1:0] word,
  output logic              ser_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned HALF    = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] SYNC_PAT =
    {{(FRAME_W - HALF){1'b0}}, {HALF{1'b1}}};

  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       sh <= '0;
    else if (load) sh <= sync_sel ? SYNC_PAT : {1'b0, word, 1'b1};
    else           sh <= {1'b0, sh[FRAME_W-1:1]};
  end

  assign ser_o = sh[0];
endmodule

// File: rtl/ser_link_seq.sv
module ser_link_seq
  import ser_link_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_WORD_W,
  parameter int unsigned LOCK_EDGES  = DEF_LOCK_EDGES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              bit_clk,
  input  logic              ref_clk,
  input  logic              pwr_down,
  input  logic              edge_sel,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic              out_en,
  input  logic [DATA_W-1:0] par_data,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              locked
);
  logic              rst;
  logic              ref_rise, ref_fall;
  logic [DATA_W-1:0] cap_data;
  logic              cap_sync;
  logic [DATA_W-1:0] word_q;
  logic              lock_q;
  logic              oe_q;
  strobe_e           strobe;

  assign strobe = strobe_e'(edge_sel);

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(bit_clk), .async_rst(pwr_down), .rst_o(rst)
  );

  ser_edge_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_edge (
    .clk(bit_clk), .ref_clk(ref_clk), .data_in(par_data),
    .sync_in(sync_req_a | sync_req_b),
    .rise_o(ref_rise), .fall_o(ref_fall),
    .data_o(cap_data), .sync_o(cap_sync)
  );

  always_ff @(posedge bit_clk or posedge rst) begin
    if (rst) word_q <= '0;
    else if ((strobe == STROBE_RISE && ref_rise) ||
             (strobe == STROBE_FALL && ref_fall))
      word_q <= cap_data;
  end

  ser_lock_ctr #(.LOCK_EDGES(LOCK_EDGES)) u_lock (
    .clk(bit_clk), .rst(rst), .tick(ref_rise), .lock_o(lock_q)
  );

  ser_frame_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(bit_clk), .rst(rst), .load(ref_rise), .sync_sel(cap_sync),
    .word(word_q), .ser_o(ser_out)
  );

  always_ff @(posedge bit_clk or posedge rst) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= lock_q & out_en;
  end

  assign ser_oe = oe_q;
  assign locked = lock_q;
endmodule

// File: rtl/ser_link_seq_chk.sv
module ser_link_seq_chk (
  input logic clk,
  input logic rst,
  input logic pwr_down,
  input logic out_en,
  input logic rise_evt,
  input logic ser_out,
  input logic ser_oe,
  input logic locked
);
  a_r7_pd_quiet: assert property (@(posedge clk)
    pwr_down |-> (!locked && !ser_oe));

  a_r5_oe_needs_lock: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> locked);

  a_r6_oe_follows_en: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> $past(out_en));

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> locked);

  a_r4_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(rise_evt));

  a_r1_start_bit: assert property (@(posedge clk) disable iff (rst)
    ($past(rise_evt) && !$past(rst)) |-> ser_out);
endmodule

bind ser_link_seq ser_link_seq_chk u_chk (
  .clk(bit_clk), .rst(rst), .pwr_down(pwr_down), .out_en(out_en),
  .rise_evt(ref_rise), .ser_out(ser_out), .ser_oe(ser_oe), .locked(locked)
);

// File: tb/ser_link_seq_test.sv
`timescale 1ns/1ps
module ser_link_seq_test;
  logic       bit_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       pwr_down = 1'b0;
  logic       edge_sel = 1'b1;
  logic       sync_req_a = 1'b0, sync_req_b = 1'b0;
  logic       out_en = 1'b1;
  logic [9:0] par_data = 10'h2A5;
  logic       ser_out, ser_oe, locked;

  always #2.5 bit_clk = ~bit_clk;

  ser_link_seq uut (
    .bit_clk(bit_clk), .ref_clk(ref_clk), .pwr_down(pwr_down),
    .edge_sel(edge_sel), .sync_req_a(sync_req_a), .sync_req_b(sync_req_b),
    .out_en(out_en), .par_data(par_data),
    .ser_out(ser_out), .ser_oe(ser_oe), .locked(locked)
  );

  int errors = 0, checks = 0;
  int pcount = 0, rph = 6, rises_since = 0;
  bit done = 1'b0, prev_lk = 1'b0;
  string tag = "R7";

  // behavioural reference state
  int        m_skip = 2, m_cnt = 0, ev_kind = 0, ev_p = 0;
  bit        m_lock = 0, m_oe = 0, ev_sync = 0;
  bit [11:0] m_frame = '0;
  bit [9:0]  m_held = '0, ev_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_lock = 0; m_oe = 0; m_cnt = 0; m_frame = '0; m_held = '0; m_skip = 2;
  endtask

  task automatic model_pos();
    bit nxt_oe;
    pcount++;
    if (ev_kind != 0 && pcount == ev_p + 1) begin
      ev_data = par_data;
      ev_sync = sync_req_a | sync_req_b;
    end
    if (pwr_down) model_clear();
    else if (m_skip > 0) m_skip--;
    else begin
      nxt_oe = m_lock & out_en;
      if (ev_kind == 1 && pcount == ev_p + 3) begin
        m_frame = ev_sync ? 12'h03F : {1'b0, m_held, 1'b1};
        if (!m_lock) begin
          m_cnt++;
          if (m_cnt == 2049) m_lock = 1;
        end
        if (edge_sel) m_held = ev_data;
      end else begin
        m_frame = m_frame >> 1;
        if (ev_kind == 2 && pcount == ev_p + 3 && !edge_sel) m_held = ev_data;
      end
      m_oe = nxt_oe;
    end
  endtask

  task automatic step();
    @(posedge bit_clk);
    model_pos();
    @(negedge bit_clk);
    chk(ser_out === m_frame[0], tag, "ser_out", int'(ser_out), int'(m_frame[0]));
    chk(ser_oe === m_oe, "R5 R6", "ser_oe", int'(ser_oe), int'(m_oe));
    chk(locked === m_lock, "R4 R9", "locked", int'(locked), int'(m_lock));
    if (locked && !prev_lk)
      chk(rises_since == 2049, "R4", "ref rises at lock", rises_since, 2049);
    prev_lk = locked;
    rph = (rph + 1) % 12;
    if (rph == 0) begin
      ref_clk = 1'b1; ev_kind = 1; ev_p = pcount;
      if (!pwr_down) rises_since++;
    end else if (rph == 6) begin
      ref_clk = 1'b0; ev_kind = 2; ev_p = pcount;
    end else if (rph == 3) begin
      par_data = {par_data[8:0], par_data[9] ^ par_data[6]};
    end
  endtask

  task automatic to_phase3();
    do step(); while (rph != 3);
  endtask

  task automatic power_down_now();
    to_phase3();
    pwr_down = 1'b1;
    model_clear();
    #1;
    chk(locked === 1'b0, "R7", "locked right after pwr_down", int'(locked), 0);
    chk(ser_oe === 1'b0, "R7", "ser_oe right after pwr_down", int'(ser_oe), 0);
  endtask

  task automatic release_pd();
    to_phase3();
    pwr_down = 1'b0;
    rises_since = 0;
  endtask

  task automatic run_to_lock();
    for (int i = 0; i < 30000 && !locked; i++) step();
    chk(locked === 1'b1, "R4", "lock reached", int'(locked), 1);
  endtask

  initial begin
    #1 pwr_down = 1'b1;
    repeat (20) step();
    chk(locked === 1'b0, "R7", "reset locked", int'(locked), 0);
    chk(ser_oe === 1'b0, "R7", "reset ser_oe", int'(ser_oe), 0);
    chk(ser_out === 1'b0, "R7", "reset ser_out", int'(ser_out), 0);

    release_pd();
    tag = "R1";
    run_to_lock();

    tag = "R2"; repeat (96) step();
    to_phase3(); edge_sel = 1'b0;
    tag = "R3"; repeat (96) step();

    to_phase3(); sync_req_a = 1'b1;
    tag = "R8"; repeat (48) step();
    to_phase3(); sync_req_a = 1'b0; sync_req_b = 1'b1;
    repeat (48) step();
    to_phase3(); sync_req_b = 1'b0;
    tag = "R1"; repeat (24) step();

    to_phase3(); out_en = 1'b0;
    tag = "R6"; repeat (36) step();
    chk(ser_oe === 1'b0, "R6", "ser_oe with out_en low", int'(ser_oe), 0);
    chk(locked === 1'b1, "R9", "lock kept with out_en low", int'(locked), 1);
    out_en = 1'b1;
    repeat (24) step();
    chk(ser_oe === 1'b1, "R6", "ser_oe restored", int'(ser_oe), 1);

    tag = "R7";
    power_down_now();
    repeat (30) step();
    release_pd();
    repeat (12 * 500) step();
    chk(locked === 1'b0, "R7", "count restarted, no early lock", int'(locked), 0);
    power_down_now();
    repeat (12) step();
    release_pd();
    run_to_lock();
    repeat (48) step();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R4 watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule